// File: doc/BRIEF.md
# Parallel Offset Register File

This block holds the two threshold offsets that a large FIFO uses for its partial-empty and partial-full flags. Each offset is three bytes wide and is kept as three byte registers, so the file has six registers in all. Software-side logic loads and reads them over the same 9-bit data buses the FIFO uses. A shared active-low load strobe diverts a write or read from the FIFO storage to the register file. Writes are taken on the write clock when the write enable is low. Reads are taken on the read clock when the read enable is low.

No address is ever given. A write pointer and a separate read pointer each walk the six registers in a fixed circular order and advance only on an access that reaches the file. Lifting the strobe or the enable pauses a walk. Lowering both again continues with the next register. When the strobe is high, the enables and data pass straight to the FIFO path. The read output register then takes the FIFO word, and a read-back of an offset byte replaces whatever FIFO word was on it.

The block presents both assembled offsets and a valid bit for each. A master reset clears everything and puts both pointers back at the start. A partial reset clears only the read output word. The pins are plain strobes and enables rather than valid/ready pairs: an access is taken on the clock edge where its enable is low, and it cannot be held off by back-pressure.

Top module: `offset_regfile`

## Requirements
- R1: On a write-clock rising edge with `ld_n`=0, `wen_n`=0 and `ren_n`=1, `din[7:0]` is stored in the register the write pointer selects, and the write pointer then advances by one.
- R2: The register order is index 0..5: indices 0,1,2 hold `empty_off` bits [7:0],[15:8],[23:16], and indices 3,4,5 hold `full_off` bits [7:0],[15:8],[23:16]. The access after index 5 goes to index 0.
- R3: On a read-clock rising edge with `ld_n`=0, `ren_n`=0 and `wen_n`=1, `q` is loaded with the byte the read pointer selects, zero-extended (`q[8]`=0), and the read pointer advances. Its pointer is independent of the write pointer.
- R4: While `mrst_n`=0, both pointers return to index 0 and all offsets, both valid bits and `q` clear to 0.
- R5: `prst_n`=0 on a read-clock edge clears `q` to 0 and changes neither pointer nor any offset.
- R6: An edge where `ld_n`=1 or the side's enable is 1 leaves that side's pointer and the offsets unchanged. The next qualifying access goes to the next register in order.
- R7: `empty_ok` is 1 only when indices 0,1,2 have all been written since the last write to index 0. `full_ok` follows the same rule for indices 3,4,5 and index 3. Both are 0 after master reset.
- R8: With `ld_n`=1: `fifo_we` = not `wen_n`, `fifo_re` = not `ren_n`, and `fifo_wdata` = `din`. A read-clock edge with `ren_n`=0 loads `q` with `fifo_rdata`.
- R9: With `ld_n`=0, `wen_n`=0 and `ren_n`=0, `coll_err` is 1. Neither access happens: the offsets, both pointers and `q` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prst_n | input | 1 | Partial reset, active low, read clock |
| ld_n | input | 1 | Load strobe, low selects the offset registers |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | 9 | Write data bus |
| fifo_rdata | input | 9 | Word from FIFO storage |
| fifo_we | output | 1 | Write request passed to FIFO storage |
| fifo_wdata | output | 9 | Write data passed to FIFO storage |
| fifo_re | output | 1 | Read request passed to FIFO storage |
| q | output | 9 | Registered read data, FIFO word or offset byte |
| empty_off | output | 24 | Assembled empty offset |
| full_off | output | 24 | Assembled full offset |
| empty_ok | output | 1 | Empty offset fully programmed |
| full_ok | output | 1 | Full offset fully programmed |
| coll_err | output | 1 | Simultaneous write and read of the file |

## Verification
The hardest state to reach is one where the two pointers sit at different, non-zero positions after a wrap. A clash or a partial reset must then be shown to move neither pointer. The bench first completes a full write pass and a full read pass, plus one extra read. It then interleaves FIFO pass-through traffic, a restart of the empty offset and a clash. Finally it pulses partial reset and checks that the next write and the next read land on the registers the untouched pointers predict.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_OFFSET = 2'd1,
    ACC_FIFO   = 2'd2,
    ACC_CLASH  = 2'd3
  } acc_e;
endpackage

// File: rtl/ofs_port_decode.sv
module ofs_port_decode
  import opf_pkg::*;
(
  input  logic ld_n,
  input  logic en_n,
  input  logic peer_en_n,
  output acc_e kind
);
  always_comb begin
    if (en_n)           kind = ACC_IDLE;
    else if (ld_n)      kind = ACC_FIFO;
    else if (!peer_en_n) kind = ACC_CLASH;
    else                kind = ACC_OFFSET;
  end
endmodule

// File: rtl/ofs_ring_ptr.sv
module ofs_ring_ptr #(
  parameter int N  = 6,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     idx <= '0;
    else if (step && idx == IW'(N-1)) idx <= '0;
    else if (step)                  idx <= idx + 1'b1;
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx == IW'(N-1)) |=> idx == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx));
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IW'(N));
endmodule

// File: rtl/ofs_byte_bank.sv
module ofs_byte_bank #(
  parameter int BW  = 8,
  parameter int BPO = 3,
  localparam int NREG = 2 * BPO,
  localparam int IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  logic [BW-1:0]      wdata,
  output logic [NREG*BW-1:0] flat,
  output logic               empty_ok,
  output logic               full_ok
);
  logic [BW-1:0] regs [NREG];
  logic          done [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_byte
    localparam int FIRST = (k / BPO) * BPO;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[k] <= '0;
        done[k] <= 1'b0;
      end else if (we && widx == IW'(k)) begin
        regs[k] <= wdata;
        done[k] <= 1'b1;
      end else if (we && widx == IW'(FIRST)) begin
        done[k] <= 1'b0;
      end
    end
    assign flat[k*BW +: BW] = regs[k];
  end

  always_comb begin
    empty_ok = 1'b1;
    full_ok  = 1'b1;
    for (int i = 0; i < BPO; i++) begin
      empty_ok = empty_ok & done[i];
      full_ok  = full_ok & done[BPO+i];
    end
  end

  a_r7_empty_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_ok) |-> $past(we && widx == IW'(BPO-1)));
  a_r7_empty_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == '0) |=> !empty_ok);
  a_r7_full_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IW'(BPO)) |=> !full_ok);
endmodule

// File: rtl/offset_regfile.sv
module offset_regfile
  import opf_pkg::*;
#(
  parameter int DW  = 9,
  parameter int BW  = 8,
  parameter int BPO = 3,
  localparam int NREG = 2 * BPO,
  localparam int IW   = $clog2(NREG),
  localparam int OW   = BPO * BW
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ld_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_re,
  output logic [DW-1:0] q,
  output logic [OW-1:0] empty_off,
  output logic [OW-1:0] full_off,
  output logic          empty_ok,
  output logic          full_ok,
  output logic          coll_err
);
  acc_e wkind, rkind;
  logic [IW-1:0] widx, ridx;
  logic [NREG*BW-1:0] flat;
  logic [BW-1:0] rd_byte;

  ofs_port_decode u_wdec (.ld_n(ld_n), .en_n(wen_n), .peer_en_n(ren_n), .kind(wkind));
  ofs_port_decode u_rdec (.ld_n(ld_n), .en_n(ren_n), .peer_en_n(wen_n), .kind(rkind));

  ofs_ring_ptr #(.N(NREG)) u_wptr (.clk(wclk), .rst_n(mrst_n),
    .step(wkind == ACC_OFFSET), .idx(widx));
  ofs_ring_ptr #(.N(NREG)) u_rptr (.clk(rclk), .rst_n(mrst_n),
    .step(rkind == ACC_OFFSET), .idx(ridx));

  ofs_byte_bank #(.BW(BW), .BPO(BPO)) u_bank (
    .clk(wclk), .rst_n(mrst_n), .we(wkind == ACC_OFFSET), .widx(widx),
    .wdata(din[BW-1:0]), .flat(flat), .empty_ok(empty_ok), .full_ok(full_ok));

  assign empty_off  = flat[OW-1:0];
  assign full_off   = flat[2*OW-1:OW];
  assign rd_byte    = flat[ridx*BW +: BW];
  assign fifo_we    = (wkind == ACC_FIFO);
  assign fifo_re    = (rkind == ACC_FIFO);
  assign fifo_wdata = din;
  assign coll_err   = (wkind == ACC_CLASH);

  always_ff @(posedge rclk) begin
    if (!mrst_n || !prst_n)        q <= '0;
    else if (rkind == ACC_OFFSET)  q <= {{(DW-BW){1'b0}}, rd_byte};
    else if (rkind == ACC_FIFO)    q <= fifo_rdata;
  end

  a_r9_clash_offsets: assert property (@(posedge wclk) disable iff (!mrst_n)
    coll_err |=> ($stable(empty_off) && $stable(full_off)));
  a_r9_clash_q: assert property (@(posedge rclk) disable iff (!mrst_n)
    (coll_err && prst_n) |=> $stable(q));
  a_r8_fifo_q: assert property (@(posedge rclk) disable iff (!mrst_n)
    (prst_n && ld_n && !ren_n) |=> q == $past(fifo_rdata));
  a_r3_top_clear: assert property (@(posedge rclk) disable iff (!mrst_n)
    (prst_n && !ld_n && !ren_n && wen_n) |=> q[DW-1:BW] == '0);
  a_r5_prst_q: assert property (@(posedge rclk) disable iff (!mrst_n)
    !prst_n |=> q == '0);
endmodule

// File: tb/sim_offset_regfile.sv
module sim_offset_regfile;
  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [8:0] din = '0, fifo_rdata = '0;
  logic fifo_we, fifo_re, empty_ok, full_ok, coll_err;
  logic [8:0] fifo_wdata, q;
  logic [23:0] empty_off, full_off;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 begin wclk = ~wclk; rclk = ~rclk; end

  offset_regfile u0 (.*);

  // {empty_ok, full_ok, byte} expected after each write of the pass
  localparam logic [9:0] TBL [6] = '{10'h011, 10'h022, 10'h233,
                                     10'h244, 10'h255, 10'h366};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic drive(input logic l, input logic w, input logic r, input logic [8:0] d);
    ld_n = l; wen_n = w; ren_n = r; din = d;
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    chk("R4 reset empty_ok", empty_ok, 0);
    chk("R4 reset full_ok", full_ok, 0);
    chk("R4 reset q", q, 0);
    chk("R4 reset offsets", {empty_off, full_off}, 0);
    mrst_n = 1'b1;
    cyc();

    // R1 R2 R7: one full write pass from the table
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 1'b0, 1'b1, {1'b0, TBL[i][7:0]});
      cyc();
      chk("R7 empty_ok in pass", empty_ok, TBL[i][9]);
      chk("R7 full_ok in pass", full_ok, TBL[i][8]);
    end
    drive(1'b1, 1'b1, 1'b1, '0);
    chk("R2 empty order", empty_off, 24'h332211);
    chk("R2 full order", full_off, 24'h665544);

    // R3: read-back in order, then the wrap
    for (int i = 0; i < 7; i++) begin
      drive(1'b0, 1'b1, 1'b0, '0);
      cyc();
      chk("R3 readback", q, {1'b0, TBL[i % 6][7:0]});
    end

    // R8: FIFO read pass-through pauses read-back
    fifo_rdata = 9'h1AB;
    drive(1'b1, 1'b1, 1'b0, '0);
    #1 chk("R8 fifo_re", fifo_re, 1);
    cyc();
    chk("R8 q from fifo", q, 9'h1AB);
    drive(1'b0, 1'b1, 1'b0, '0);
    cyc();
    chk("R6 read resumes", q, 9'h022);

    // R2 R7: write wraps to index 0 and restarts the empty offset
    drive(1'b0, 1'b0, 1'b1, 9'h0A0);
    cyc();
    chk("R2 wrap write", empty_off, 24'h3322A0);
    chk("R7 empty restarted", empty_ok, 0);
    chk("R7 full kept", full_ok, 1);

    // R8 R6: FIFO write pass-through
    drive(1'b1, 1'b0, 1'b1, 9'h15A);
    #1 chk("R8 fifo_we", fifo_we, 1);
    chk("R8 fifo_wdata", fifo_wdata, 9'h15A);
    cyc();
    chk("R6 offsets held", empty_off, 24'h3322A0);
    drive(1'b0, 1'b0, 1'b1, 9'h0B1);
    cyc();
    chk("R6 write resumes", empty_off, 24'h33B1A0);

    // R9: clash
    drive(1'b0, 1'b0, 1'b0, 9'h0CC);
    #1 chk("R9 coll_err", coll_err, 1);
    chk("R9 no fifo_we", fifo_we, 0);
    cyc();
    chk("R9 empty held", empty_off, 24'h33B1A0);
    chk("R9 full held", full_off, 24'h665544);
    chk("R9 q held", q, 9'h022);
    drive(1'b1, 1'b1, 1'b1, '0);
    #1 chk("R9 coll_err clear", coll_err, 0);

    // R5: partial reset
    prst_n = 1'b0;
    cyc();
    prst_n = 1'b1;
    chk("R5 q cleared", q, 0);
    chk("R5 offsets kept", empty_off, 24'h33B1A0);
    drive(1'b0, 1'b0, 1'b1, 9'h0C2);
    cyc();
    chk("R5 wptr kept", empty_off, 24'hC2B1A0);
    chk("R7 empty complete", empty_ok, 1);
    drive(1'b0, 1'b1, 1'b0, '0);
    cyc();
    chk("R5 rptr kept", q, 9'h0C2);

    // R6: strobe low, both enables high
    drive(1'b0, 1'b1, 1'b1, 9'h0EE);
    cyc();
    chk("R6 idle q", q, 9'h0C2);
    chk("R6 idle offsets", empty_off, 24'hC2B1A0);

    // R4: master reset
    mrst_n = 1'b0;
    cyc();
    mrst_n = 1'b1;
    chk("R4 mrst offsets", {empty_off, full_off}, 0);
    chk("R4 mrst valid", {empty_ok, full_ok}, 0);
    drive(1'b0, 1'b0, 1'b1, 9'h05D);
    cyc();
    chk("R4 wptr at 0", empty_off, 24'h00005D);
    drive(1'b0, 1'b1, 1'b0, '0);
    cyc();
    chk("R4 rptr at 0", q, 9'h05D);
    drive(1'b1, 1'b1, 1'b1, '0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule